// File: doc/BRIEF.md
# Activity Watchdog Timer

The block watches one activity line and asks the reset controller for a system reset when that line has gone quiet for too long. The line is either a dedicated kick input or a serial data line. A build-time parameter picks which one. Any change of level on the watched line, up or down, restarts the idle interval. If the interval runs out, the block raises a one-cycle expiry request.

The idle limit is a parameter counted in clock cycles. The default is 1.6 s at a 250 MHz clock. The watched line is brought into the clock domain through a two-flop synchronizer, and a level change is found by comparing two successive synchronized samples. The system reset state is the block's synchronous active-high reset. While it is asserted, the idle counter stays at zero and no request is made. The counter stops at the limit, so one idle period gives only one request. Shaping the reset pulse itself is left to the reset controller.

Top module: `activity_watchdog`

## Requirements
- R1: While `rst` is high at a rising clock edge, the idle count is cleared and `expire_req` is 0 after that edge.
- R2: A rising level change on the watched line restarts the interval. A change first sampled at edge k is acted on at edge k+2, and with no further activity `expire_req` pulses after edge k+2+TIMEOUT_CYCLES.
- R3: A falling level change on the watched line restarts the interval with the same timing as R2.
- R4: After reset is released, with the line steady, `expire_req` goes high after the TIMEOUT_CYCLES-th rising edge with `rst` low.
- R5: `expire_req` is high for exactly one cycle per idle period. The count stops at the limit, so a line that stays idle gives no second pulse.
- R6: When a level change is acted on at the same edge where the count would reach the limit, the restart wins and no pulse is issued.
- R7: Activity on the line that is not selected has no effect on `expire_req`.
- R8: With SRC_SEL = WDT_SRC_KICK (value 0) the block watches `kick_line`. With SRC_SEL = WDT_SRC_DATA (value 1) it watches `data_line`.
- R9: Asserting `rst` part way through an idle period discards the count. After release, a full TIMEOUT_CYCLES interval is needed before a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset state, synchronous, active high; holds the timer cleared |
| kick_line | input | 1 | Dedicated activity input (asynchronous) |
| data_line | input | 1 | Serial data line used as an activity source (asynchronous) |
| expire_req | output | 1 | One-cycle watchdog expiry request to the reset controller |

## Verification
Two functions can meet in one cycle: the restart caused by a detected level change, and the count reaching its limit. The bench provokes this by releasing reset and then toggling the watched line exactly TIMEOUT_CYCLES-2 edges later. The change is then acted on at the very edge where the limit would be reached. The outcome is judged by the absence of any pulse in the following window, and by the next pulse arriving a full interval after that edge. The behavioural model is compared against the design on every clock throughout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Which activity line the watchdog observes.
    typedef enum logic {
        WDT_SRC_KICK = 1'b0,
        WDT_SRC_DATA = 1'b1
    } wdt_src_e;

    // Number of synchronizer flops ahead of the edge compare.
    localparam int unsigned WDT_SYNC_STAGES = 2;

    // Counter width able to hold the terminal value itself.
    function automatic int unsigned wdt_cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_async,
    output logic toggled
);
    // pipe[STAGES-1] is the newest synchronized sample, pipe[STAGES] the previous one.
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], line_async};
        end
    end

    assign toggled = pipe[STAGES] ^ pipe[STAGES-1];
endmodule

// File: rtl/wdt_idle_counter.sv
module wdt_idle_counter #(
    parameter int unsigned LIMIT = 16,
    parameter int unsigned CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [CW-1:0] count,
    output logic          expired
);
    localparam logic [CW-1:0] TERM     = CW'(LIMIT);
    localparam logic [CW-1:0] PRE_TERM = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } idle_state_t;

    idle_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        nxt.pulse = 1'b0;
        if (restart) begin
            nxt.cnt = '0;
        end else if (cur.cnt != TERM) begin
            nxt.cnt   = cur.cnt + 1'b1;
            nxt.pulse = (cur.cnt == PRE_TERM);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign count   = cur.cnt;
    assign expired = cur.pulse;
endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 400_000_000,
    parameter wdt_src_e    SRC_SEL        = WDT_SRC_KICK
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_line,
    input  logic data_line,
    output logic expire_req
);
    localparam int unsigned CNT_W = wdt_cnt_width(TIMEOUT_CYCLES);

    logic             watched;
    logic             line_toggled;
    logic [CNT_W-1:0] idle_cnt;

    assign watched = (SRC_SEL == WDT_SRC_DATA) ? data_line : kick_line;

    wdt_edge_sync #(
        .STAGES(WDT_SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .line_async(watched),
        .toggled   (line_toggled)
    );

    wdt_idle_counter #(
        .LIMIT(TIMEOUT_CYCLES),
        .CW   (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .restart(line_toggled),
        .count  (idle_cnt),
        .expired(expire_req)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int unsigned TIMEOUT_CYCLES = 16,
    parameter int unsigned CNT_W          = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             kick,
    input logic [CNT_W-1:0] idle_cnt,
    input logic             expire_req
);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMEOUT_CYCLES);

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (idle_cnt == '0 && !expire_req));

    assert_kick_restarts_R2: assert property (@(posedge clk) disable iff (rst)
        kick |=> (idle_cnt == '0 && !expire_req));

    assert_idle_advances_R4: assert property (@(posedge clk) disable iff (rst)
        (!kick && idle_cnt != TERM) |=> (idle_cnt == $past(idle_cnt) + 1'b1));

    assert_pulse_at_limit_R4: assert property (@(posedge clk) disable iff (rst)
        expire_req |-> (idle_cnt == TERM));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        expire_req |=> !expire_req);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        idle_cnt <= TERM);
endmodule

bind activity_watchdog wdt_checker #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .CNT_W         (CNT_W)
) u_wdt_checker (
    .clk       (clk),
    .rst       (rst),
    .kick      (line_toggled),
    .idle_cnt  (idle_cnt),
    .expire_req(expire_req)
);

// File: tb/tb_activity_watchdog.sv
module tb_activity_watchdog;
    import wdt_pkg::*;

    localparam int unsigned T = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick_line = 1'b0;
    logic data_line = 1'b0;
    logic exp_a, exp_b;

    int checks = 0;
    int errors = 0;
    int pulses_a = 0;
    int pulses_b = 0;

    always #2 clk = ~clk;

    activity_watchdog #(.TIMEOUT_CYCLES(T), .SRC_SEL(WDT_SRC_KICK)) dut (
        .clk(clk), .rst(rst), .kick_line(kick_line), .data_line(data_line), .expire_req(exp_a));

    activity_watchdog #(.TIMEOUT_CYCLES(T), .SRC_SEL(WDT_SRC_DATA)) dut_alt (
        .clk(clk), .rst(rst), .kick_line(kick_line), .data_line(data_line), .expire_req(exp_b));

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Behavioural reference: history of sampled levels plus an idle counter.
    bit hist_a[$] = '{0, 0, 0};
    bit hist_b[$] = '{0, 0, 0};
    int unsigned idle_a = 0, idle_b = 0;
    bit mexp_a = 0, mexp_b = 0;

    task automatic model_step(input bit r, input bit line, ref bit h[$],
                              ref int unsigned idle, ref bit ex);
        bit seen;
        if (r) begin
            idle = 0;
            ex = 0;
            h = '{0, 0, 0};
        end else begin
            seen = (h[h.size()-2] != h[h.size()-3]);
            ex = 0;
            if (seen) idle = 0;
            else if (idle < T) begin
                idle++;
                ex = (idle == T);
            end
            h.push_back(line);
            if (h.size() > 6) void'(h.pop_front());
        end
    endtask

    always @(posedge clk) begin
        model_step(rst, kick_line, hist_a, idle_a, mexp_a);
        model_step(rst, data_line, hist_b, idle_b, mexp_b);
        #1;
        check(exp_a == mexp_a, "R4 per-cycle model (kick source)", int'(exp_a), int'(mexp_a));
        check(exp_b == mexp_b, "R8 per-cycle model (data source)", int'(exp_b), int'(mexp_b));
        if (exp_a) pulses_a++;
        if (exp_b) pulses_b++;
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1.5;
    endtask

    task automatic latency(input int maxn, output int lat);
        lat = -1;
        for (int i = 1; i <= maxn; i++) begin
            @(posedge clk);
            #1.5;
            if (exp_a) begin
                lat = i;
                break;
            end
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        kick_line = 1'b0;
        data_line = 1'b0;
        repeat (n) @(negedge clk);
        rst = 1'b0;
    endtask

    int pa0, pb0, lat;

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                check(exp_a == 1'b0 && exp_b == 1'b0, "R1 quiet while in reset", int'(exp_a), 0);
                do_reset(2);
                // R4: first pulse after T-th edge with rst low
                latency(T + 5, lat);
                check(lat == T, "R4 expiry latency after reset", lat, T);
                check(pulses_b == 1, "R8 data-source unit also expires", pulses_b, 1);
                pa0 = pulses_a;
                cycles(3 * T);
                check(pulses_a == pa0, "R5 no second pulse while idle", pulses_a - pa0, 0);

                // R2 rising change
                pb0 = pulses_b;
                @(negedge clk); kick_line = 1'b1;
                latency(T + 10, lat);
                check(lat == T + 3, "R2 rising change restarts interval", lat, T + 3);
                check(pulses_b == pb0, "R7 kick line ignored by data-source unit", pulses_b - pb0, 0);

                // R3 falling change
                @(negedge clk); kick_line = 1'b0;
                latency(T + 10, lat);
                check(lat == T + 3, "R3 falling change restarts interval", lat, T + 3);

                // Regular kicks keep the kick-source unit quiet (R2)
                pa0 = pulses_a;
                for (int k = 0; k < 10; k++) begin
                    @(negedge clk); kick_line = ~kick_line;
                    repeat (T / 2) @(negedge clk);
                end
                check(pulses_a == pa0, "R2 periodic kicks prevent expiry", pulses_a - pa0, 0);

                // Data line activity: ignored by kick unit (R7), watched by data unit (R8)
                pa0 = pulses_a;
                pb0 = pulses_b;
                for (int k = 0; k < 10; k++) begin
                    @(negedge clk); data_line = ~data_line;
                    repeat (T / 2) @(negedge clk);
                end
                check(pulses_a == pa0 + 1, "R7 data activity ignored by kick unit", pulses_a - pa0, 1);
                check(pulses_b == pb0, "R8 data unit kept alive by data line", pulses_b - pb0, 0);

                // R6 collision: change acted on at the limit edge
                do_reset(2);
                repeat (T - 3) @(posedge clk);
                @(negedge clk); kick_line = ~kick_line;
                pa0 = pulses_a;
                cycles(T);
                check(pulses_a == pa0, "R6 restart wins over limit", pulses_a - pa0, 0);
                latency(10, lat);
                check(lat == 3, "R6 next pulse a full interval after restart", lat, 3);

                // R9 reset mid-count
                do_reset(2);
                cycles(T / 2);
                pa0 = pulses_a;
                do_reset(3);
                latency(2 * T, lat);
                check(lat == T, "R9 full interval after mid-count reset", lat, T);
                check(pulses_a == pa0 + 1, "R9 no early pulse", pulses_a - pa0, 1);
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule